// File: doc/BRIEF.md
# Strobe-Handshaked FIFO with Occupancy Flags

This block is a first-in first-out buffer of 64 words by 9 bits. Each side has a strobe-and-ready handshake. A producer watches `in_rdy_o`, and while it is high, a rising edge on `shift_in_i` captures `data_i`. The strobe's falling edge then commits the word. A consumer watches `out_rdy_o`, and while it is high, `data_o` holds the oldest stored word. A rising edge on `shift_out_i` takes that word, and the falling edge releases its slot.

Both strobes may come from slow or unrelated logic. Each one passes through a two-stage synchroniser into the block clock, and its edges are detected there. Two occupancy flags decode the word count:
- A combined near-limit flag covers both the nearly-empty band and the nearly-full band.
- A half-full flag covers the upper half.

Storage uses a RAM with wrapping read and write pointers, so words never move inside the buffer. When the buffer drains, `data_o` keeps the last word shown.

Top module: `strobe_fifo`

## Requirements
- R1: Words leave in the order they entered, and the buffer holds up to 64 words.
- R2: `in_rdy_o` goes low after an accepted rising edge of `shift_in_i`. It goes high again after the falling edge of `shift_in_i`, unless 64 words are then stored, in which case it stays low.
- R3: A `shift_in_i` pulse while 64 words are stored is ignored: nothing is written and the count stays at 64.
- R4: A `shift_out_i` pulse while `out_rdy_o` is low is ignored: `data_o` and the count do not change.
- R5: `out_rdy_o` goes low after an accepted rising edge of `shift_out_i`. While `out_rdy_o` is high, `data_o` is stable. The next word and a high `out_rdy_o` appear only after the falling edge of `shift_out_i`.
- R6: `near_lim_o` is 1 when the count is 8 or less, or 56 or more, and 0 otherwise.
- R7: `half_o` is 1 when the count is 32 or more, and 0 otherwise.
- R8: The count, and so both flags, changes only after a falling edge of a strobe. A rising edge alone leaves the flags as they were.
- R9: While `rst_ni` is low, the block is empty, with `in_rdy_o`=1, `out_rdy_o`=0, `data_o`=0, `near_lim_o`=1 and `half_o`=0. `data_o` stays 0 until a word is presented.
- R10: When the buffer empties, `data_o` keeps the last word read until a new word is presented or reset is applied.
- R11: If `shift_out_i` is already high when a word arrives in an empty buffer, that word is presented with `out_rdy_o` high for exactly one clock and is then consumed. Later words wait, with `out_rdy_o` low, until `shift_out_i` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_in_i | input | 1 | Write strobe; its rising edge captures data, its falling edge commits the word |
| data_i | input | 9 | Write data |
| in_rdy_o | output | 1 | A free slot exists and no write is pending |
| shift_out_i | input | 1 | Read strobe; its rising edge takes the word, its falling edge frees the slot |
| out_rdy_o | output | 1 | `data_o` holds a valid word |
| data_o | output | 9 | Oldest word, or the last word read |
| near_lim_o | output | 1 | Count is 8 or less, or 56 or more |
| half_o | output | 1 | Count is 32 or more |

## Verification
A strobe edge driven between clock edges takes effect on the third rising clock edge: two edges for the synchroniser and one for the control register. A newly eligible word needs one more edge to be presented. The bench therefore waits six cycles after every strobe change before it compares results. The only exception is the fall-through pulse, which lasts a single cycle. For that case the bench samples on exactly the fourth and fifth edges after the falling edge of `shift_in_i`. All comparisons take place on the falling clock edge.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } strobe_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
  import strobe_fifo_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    strobe_i,
  output strobe_t ev_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  // level is the last synchroniser stage, the extra stage is for edge detect
  assign ev_o.lvl  = sh_q[STAGES-1];
  assign ev_o.rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign ev_o.fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_adv_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_en_i)  wptr_q <= bump(wptr_q);
      if (rd_adv_i) rptr_q <= bump(rptr_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wptr_q] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rptr_q];
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
  parameter int DEPTH     = 64,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 56,
  parameter int HALF_MARK = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          near_lim_o,
  output logic          half_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign count_o    = cnt_q;
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign near_lim_o = (cnt_q <= CW'(LOW_MARK)) || (cnt_q >= CW'(HIGH_MARK));
  assign half_o     = (cnt_q >= CW'(HALF_MARK));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH     = 9,
  parameter int DEPTH     = 64,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 56,
  parameter int HALF_MARK = DEPTH / 2,
  parameter int SYNC_STG  = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_in_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             in_rdy_o,
  input  logic             shift_out_i,
  output logic             out_rdy_o,
  output logic [WIDTH-1:0] data_o,
  output logic             near_lim_o,
  output logic             half_o
);
  strobe_t          si_ev, so_ev;
  logic             wr_pend_q, rd_pend_q, out_rdy_q;
  logic [WIDTH-1:0] dout_q, rd_data;
  logic             wr_en, inc, dec, consume, present;
  logic             full, empty;
  logic [CW-1:0]    fill_cnt;

  strobe_sync #(.STAGES(SYNC_STG)) u_si_sync (
    .clk_i, .rst_ni, .strobe_i(shift_in_i), .ev_o(si_ev)
  );
  strobe_sync #(.STAGES(SYNC_STG)) u_so_sync (
    .clk_i, .rst_ni, .strobe_i(shift_out_i), .ev_o(so_ev)
  );

  assign in_rdy_o = !wr_pend_q && !full;
  assign wr_en    = si_ev.rise && in_rdy_o;
  assign inc      = wr_pend_q && si_ev.fall;
  // a high strobe level consumes the shown word, covering the held-high case
  assign consume  = out_rdy_q && so_ev.lvl;
  assign dec      = rd_pend_q && so_ev.fall;
  assign present  = !out_rdy_q && !rd_pend_q && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      rd_pend_q <= 1'b0;
      out_rdy_q <= 1'b0;
      dout_q    <= '0;
    end else begin
      if (wr_en)    wr_pend_q <= 1'b1;
      else if (inc) wr_pend_q <= 1'b0;
      if (consume) begin
        out_rdy_q <= 1'b0;
        rd_pend_q <= 1'b1;
      end else if (dec) begin
        rd_pend_q <= 1'b0;
      end else if (present) begin
        out_rdy_q <= 1'b1;
        dout_q    <= rd_data;
      end
    end
  end

  fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_data_i(data_i),
    .rd_adv_i(dec), .rd_data_o(rd_data)
  );

  fill_tracker #(
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK), .HALF_MARK(HALF_MARK)
  ) u_fill (
    .clk_i, .rst_ni, .inc_i(inc), .dec_i(dec),
    .count_o(fill_cnt), .full_o(full), .empty_o(empty),
    .near_lim_o, .half_o
  );

  assign out_rdy_o = out_rdy_q;
  assign data_o    = dout_q;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             out_rdy_o,
  input logic [WIDTH-1:0] data_o,
  input logic             near_lim_o,
  input logic             half_o,
  input logic             so_lvl,
  input logic             si_fall,
  input logic             so_fall,
  input logic             wr_en,
  input logic [CW-1:0]    fill_cnt
);
  a_r3_no_write_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_cnt == CW'(DEPTH)) |-> !wr_en);

  a_r5_stable_while_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rdy_o |=> (!out_rdy_o || $stable(data_o)));

  a_r8_half_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(half_o) |-> $past(si_fall || so_fall));

  a_r8_near_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(near_lim_o) |-> $past(si_fall || so_fall));

  a_r10_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(data_o) |-> out_rdy_o);

  a_r11_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_rdy_o && so_lvl) |=> !out_rdy_o);

  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt <= CW'(DEPTH));
endmodule

bind strobe_fifo strobe_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .out_rdy_o(out_rdy_o), .data_o(data_o),
  .near_lim_o(near_lim_o), .half_o(half_o), .so_lvl(so_ev.lvl),
  .si_fall(si_ev.fall), .so_fall(so_ev.fall), .wr_en(wr_en), .fill_cnt(fill_cnt)
);

// File: tb/strobe_fifo_tb.sv
module strobe_fifo_tb;
  localparam int W = 9;
  localparam int D = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         shift_in_i = 1'b0, shift_out_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         in_rdy_o, out_rdy_o, near_lim_o, half_o;
  logic [W-1:0] data_o;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] last_word;

  always #5 clk_i = ~clk_i;

  strobe_fifo u_dut (
    .clk_i, .rst_ni, .shift_in_i, .data_i, .in_rdy_o,
    .shift_out_i, .out_rdy_o, .data_o, .near_lim_o, .half_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_flags();
    int n = q.size();
    bit ea = (n <= 8) || (n >= 56);
    bit eh = (n >= 32);
    chk(near_lim_o == ea, "R6 near_lim", near_lim_o, ea);
    chk(half_o == eh, "R7 half", half_o, eh);
  endtask

  task automatic push(input logic [W-1:0] d);
    chk(in_rdy_o == 1'b1, "R2 ready before write", in_rdy_o, 1);
    data_i = d;
    shift_in_i = 1'b1;
    wt(6);
    chk(in_rdy_o == 1'b0, "R2 ack after rise", in_rdy_o, 0);
    chk_flags(); // R8: rise alone leaves flags
    shift_in_i = 1'b0;
    q.push_back(d);
    wt(6);
    chk(in_rdy_o == (q.size() < D), "R2 recover after fall", in_rdy_o, q.size() < D);
    chk_flags();
  endtask

  task automatic pop();
    logic [W-1:0] e = q[0];
    chk(out_rdy_o == 1'b1, "R5 ready", out_rdy_o, 1);
    chk(data_o == e, "R1 order", data_o, e);
    shift_out_i = 1'b1;
    wt(6);
    chk(out_rdy_o == 1'b0, "R5 drop after rise", out_rdy_o, 0);
    chk(data_o == e, "R5 data held", data_o, e);
    chk_flags(); // R8
    shift_out_i = 1'b0;
    void'(q.pop_front());
    last_word = e;
    wt(6);
    chk_flags();
    if (q.size() == 0) begin
      chk(out_rdy_o == 1'b0, "R10 empty ready", out_rdy_o, 0);
      chk(data_o == last_word, "R10 last word kept", data_o, last_word);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    #1;
    // R9 reset state
    chk(in_rdy_o == 1, "R9 in_rdy", in_rdy_o, 1);
    chk(out_rdy_o == 0, "R9 out_rdy", out_rdy_o, 0);
    chk(data_o == 0, "R9 data", data_o, 0);
    chk(near_lim_o == 1, "R9 near_lim", near_lim_o, 1);
    chk(half_o == 0, "R9 half", half_o, 0);
    wt(3);
    rst_ni = 1'b1;
    wt(3);
    chk(data_o == 0 && out_rdy_o == 0, "R9 low until write", data_o, 0);

    // R1/R6/R7 fill to full, every count boundary
    for (int i = 0; i < D; i++) push(W'((i * 37 + 5) & 9'h1FF));
    // R3 pulse while full
    shift_in_i = 1'b1; data_i = 9'h1AA;
    wt(6);
    chk(in_rdy_o == 0, "R3 full not ready", in_rdy_o, 0);
    shift_in_i = 1'b0;
    wt(6);
    chk(in_rdy_o == 0, "R3 stays not ready", in_rdy_o, 0);
    chk_flags();
    // drain; any stored extra word would break R1 ordering
    for (int i = 0; i < D; i++) pop();
    chk(in_rdy_o == 1, "R3 ready after drain", in_rdy_o, 1);

    // R4 pulse while empty
    shift_out_i = 1'b1;
    wt(6);
    shift_out_i = 1'b0;
    wt(6);
    chk(out_rdy_o == 0, "R4 no ready", out_rdy_o, 0);
    chk(data_o == last_word, "R4 data unchanged", data_o, last_word);
    chk_flags();

    // second pass with wrapped pointers, interleaved
    for (int i = 0; i < 20; i++) begin
      push(W'(9'h1FF - i * 11));
      if (i % 3 == 2) pop();
    end
    while (q.size() > 0) pop();

    // R11 fall-through with read strobe held high
    shift_out_i = 1'b1;
    wt(6);
    data_i = 9'h0C3;
    shift_in_i = 1'b1;
    wt(6);
    shift_in_i = 1'b0;
    q.push_back(9'h0C3);
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    chk(out_rdy_o == 1, "R11 pulse high", out_rdy_o, 1);
    chk(data_o == 9'h0C3, "R11 word shown", data_o, 9'h0C3);
    @(negedge clk_i);
    chk(out_rdy_o == 0, "R11 pulse one cycle", out_rdy_o, 0);
    wt(4);
    push(9'h055);
    push(9'h1E1);
    chk(out_rdy_o == 0, "R11 later words wait", out_rdy_o, 0);
    chk(data_o == 9'h0C3, "R11 word kept", data_o, 9'h0C3);
    shift_out_i = 1'b0;
    void'(q.pop_front());
    wt(6);
    chk_flags();
    chk(out_rdy_o == 1 && data_o == 9'h055, "R11 next after low", data_o, 9'h055);
    pop();

    // R9 reset mid-stream
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    q.delete();
    chk(in_rdy_o == 1 && out_rdy_o == 0, "R9 reset handshake", out_rdy_o, 0);
    chk(data_o == 0, "R9 reset data", data_o, 0);
    chk_flags();
    wt(2);
    rst_ni = 1'b1;
    wt(3);
    push(9'h123);
    pop();
    finish_run();
  end
endmodule